// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table from memory. It keeps its own directory base register, which is loaded through a small write port. A translation request is accepted only while the walker is idle. The walker then reads a directory entry through a single-outstanding read port. If that entry allows it, the walker reads a page table entry. Each read waits through a request handshake and then a response strobe, and both may take any number of cycles.

The walk ends with a one-cycle response. It carries one of three things: a physical address, a page fault (an entry is not present), or a protection fault (a write reached a read-only entry). An ordinary read can only be refused by a missing entry. The result also reports whether the page is cacheable, taken from the leaf entry.

Top module: `pgwalk_top`

## Requirements
- R1: After reset `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: The first read of a walk goes to address {base[31:12], vaddr[31:22], 2'b00}. Here base is the directory base register value.
- R3: The second read goes to address {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R4: A successful walk returns code 0 and `rsp_paddr` = {leaf_entry[31:12], vaddr[11:0]}. `rsp_cacheable` equals bit 3 of the leaf entry.
- R5: If bit 0 (present) of the directory entry is 0, the walk returns code 1 (page fault) with a zero address and no cacheable flag. No second read is issued.
- R6: If bit 0 of the leaf entry is 0, the walk returns code 1 with a zero address and no cacheable flag.
- R7: A write request (`req_write`=1) that meets an entry with bit 1 (read-only) set returns code 2 (protection fault). If this happens at the directory level, no second read is issued. Read requests ignore bit 1. A missing entry takes priority and reports code 1.
- R8: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. Any delay before the handshake and before `mem_rsp_valid` is tolerated.
- R9: A request is taken only while `req_ready` is 1. While a walk runs, `req_valid` has no effect on the reads issued or on the result.
- R10: `base_load` writes `base_value` into the directory base register. A request accepted in the same cycle as a load still uses the previous base value, and later requests use the new one.
- R11: Every accepted request produces exactly one `rsp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_load | input | 1 | Load the directory base register |
| base_value | input | 32 | New directory base (bits 31:12 used) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result, one-cycle pulse |
| rsp_code | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_cacheable | output | 1 | Leaf entry marks the page cacheable |

## Verification
Two events can land in the same clock edge: a load of the directory base register and the acceptance of a translation request. The bench raises `base_load` and `req_valid` in the same cycle, each with a different base value. It then checks that the directory read goes to the address built from the old base, and that the next walk uses the new one. A second overlap is a new `req_valid` that stays high during a running walk. In that case the bench checks that only the original walk's reads are issued and that its result is unchanged.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_WT_DIR, ST_RD_PTE, ST_WT_PTE, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_PAGE = 2'd1,
    RES_PROT = 2'd2
  } walk_res_e;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_RDONLY  = 1;
  localparam int BIT_CACHE   = 3;
endpackage

// File: rtl/pgwalk_addr.sv
// Builds the entry address of one table level: page base, index, entry-size zeros.
module pgwalk_addr #(
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 10,
  parameter int ENT_LOG = 2
) (
  input  logic [PPN_W-1:0]               base_ppn,
  input  logic [IDX_W-1:0]               index,
  output logic [PPN_W+IDX_W+ENT_LOG-1:0] ent_addr
);
  always_comb ent_addr = {base_ppn, index, {ENT_LOG{1'b0}}};
endmodule

// File: rtl/pgwalk_entry_chk.sv
// Judges one fetched entry: absence first, then write to read-only.
module pgwalk_entry_chk #(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0]     entry,
  input  logic                 is_write,
  output pgwalk_pkg::walk_res_e verdict
);
  import pgwalk_pkg::*;
  always_comb begin
    if (!entry[BIT_PRESENT])                verdict = RES_PAGE;
    else if (is_write && entry[BIT_RDONLY]) verdict = RES_PROT;
    else                                    verdict = RES_OK;
  end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    mem_req_ready,
  input  logic                    mem_rsp_valid,
  input  pgwalk_pkg::walk_res_e   verdict,
  output pgwalk_pkg::walk_state_e state
);
  import pgwalk_pkg::*;
  walk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (req_valid) nxt = ST_RD_DIR;
      ST_RD_DIR: if (mem_req_ready) nxt = ST_WT_DIR;
      ST_WT_DIR: if (mem_rsp_valid) nxt = (verdict == RES_OK) ? ST_RD_PTE : ST_DONE;
      ST_RD_PTE: if (mem_req_ready) nxt = ST_WT_PTE;
      ST_WT_PTE: if (mem_rsp_valid) nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R8: a waiting state is left only on a response
  p_wait_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WT_DIR && !mem_rsp_valid) |=> state == ST_WT_DIR);
  // R5: a refused directory entry never leads to a leaf read
  p_dir_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WT_DIR && mem_rsp_valid && verdict != RES_OK) |=> state == ST_DONE);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ENT_W     = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            base_load,
  input  logic [PA_W-1:0] base_value,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_cacheable
);
  import pgwalk_pkg::*;

  localparam int PPN_W   = PA_W - PAGE_BITS;
  localparam int ENT_LOG = $clog2(ENT_W / 8);
  localparam int LEVELS  = 2;
  localparam int LOW_W   = VA_W - IDX_W;   // vaddr bits still needed after acceptance

  walk_state_e state;
  walk_res_e   verdict;

  logic [PA_W-1:0]  base_q;
  logic [LOW_W-1:0] va_q;
  logic             wr_q;
  logic [PA_W-1:0]  addr_q;
  logic [1:0]       code_q;
  logic [PA_W-1:0]  paddr_q;
  logic             cache_q;

  // Per-level address formation: level 0 from the base register, level 1 from the directory entry.
  logic [PPN_W-1:0] lvl_base [LEVELS];
  logic [IDX_W-1:0] lvl_idx  [LEVELS];
  logic [PA_W-1:0]  lvl_addr [LEVELS];

  always_comb begin
    lvl_base[0] = base_q[PA_W-1 -: PPN_W];
    lvl_idx[0]  = req_vaddr[VA_W-1 -: IDX_W];
    lvl_base[1] = mem_rsp_data[ENT_W-1 -: PPN_W];
    lvl_idx[1]  = va_q[PAGE_BITS +: IDX_W];
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    pgwalk_addr #(.PPN_W(PPN_W), .IDX_W(IDX_W), .ENT_LOG(ENT_LOG)) u_addr (
      .base_ppn (lvl_base[lv]),
      .index    (lvl_idx[lv]),
      .ent_addr (lvl_addr[lv])
    );
  end

  pgwalk_entry_chk #(.ENT_W(ENT_W)) u_chk (
    .entry    (mem_rsp_data),
    .is_write (wr_q),
    .verdict  (verdict)
  );

  pgwalk_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .verdict       (verdict),
    .state         (state)
  );

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (base_load) base_q <= base_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      code_q  <= RES_OK;
      paddr_q <= '0;
      cache_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr[LOW_W-1:0];
          wr_q   <= req_write;
          addr_q <= lvl_addr[0];
        end
        ST_WT_DIR: if (mem_rsp_valid) begin
          if (verdict == RES_OK) begin
            addr_q <= lvl_addr[1];
          end else begin
            code_q  <= verdict;
            paddr_q <= '0;
            cache_q <= 1'b0;
          end
        end
        ST_WT_PTE: if (mem_rsp_valid) begin
          code_q <= verdict;
          if (verdict == RES_OK) begin
            paddr_q <= {mem_rsp_data[ENT_W-1 -: PPN_W], va_q[PAGE_BITS-1:0]};
            cache_q <= mem_rsp_data[BIT_CACHE];
          end else begin
            paddr_q <= '0;
            cache_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_RD_DIR) || (state == ST_RD_PTE);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_code      = code_q;
  assign rsp_paddr     = paddr_q;
  assign rsp_cacheable = cache_q;

  // R4: offset bits of a good result match the request
  p_offset_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RES_OK) |-> rsp_paddr[PAGE_BITS-1:0] == va_q[PAGE_BITS-1:0]);
  // R5/R6: a fault carries no address and no cacheable flag
  p_fault_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != RES_OK) |-> (rsp_paddr == '0 && !rsp_cacheable));
  // R8: request held steady until taken
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R9: busy right after accepting
  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R11: result is a single-cycle pulse
  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R7: no protection fault reported for a read
  p_read_noprot_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !wr_q) |-> rsp_code != RES_PROT);
endmodule

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_load = 1'b0;
  logic [31:0] base_value = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [31:0] rsp_paddr;
  logic rsp_cacheable;

  always #5 clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rst(rst), .base_load(base_load), .base_value(base_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
    .rsp_cacheable(rsp_cacheable)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sparse memory and responder
  logic [31:0] mem [logic [31:0]];
  logic [31:0] seen [4];
  int n_reads = 0;
  int ready_gap = 0;
  int rsp_gap = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] first_addr;
        first_addr = mem_req_addr;
        repeat (ready_gap) @(negedge clk);
        chk(mem_req_valid && mem_req_addr == first_addr, "R8 held request", mem_req_addr, first_addr);
        mem_req_ready = 1'b1;
        if (n_reads < 4) seen[n_reads] = mem_req_addr;
        n_reads++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (rsp_gap) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(seen[n_reads-1]);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [31:0] base;
    logic [19:0] ptbase;
    logic [11:0] pde_ctl;
    logic [19:0] ppn;
    logic [11:0] pte_ctl;
    logic [1:0]  code;
    logic [1:0]  nreads;
  } vec_t;

  // ctl bits: 0 present, 1 read-only, 3 cacheable; code 0 ok, 1 page, 2 prot
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 1'b0, 32'h0010_0FFF, 20'h00200, 12'h001, 20'hABCDE, 12'h009, 2'd0, 2'd2}, // R4 cacheable
    '{32'h8000_1ABC, 1'b1, 32'h0020_0000, 20'h00300, 12'h005, 20'h12345, 12'h005, 2'd0, 2'd2}, // R4 write ok
    '{32'h0040_2000, 1'b0, 32'h0030_0000, 20'h00400, 12'h000, 20'h11111, 12'h001, 2'd1, 2'd1}, // R5
    '{32'hCAFE_B00C, 1'b0, 32'h0040_0000, 20'h00500, 12'h001, 20'h22222, 12'h00E, 2'd1, 2'd2}, // R6
    '{32'h7777_7777, 1'b1, 32'h0050_0000, 20'h00600, 12'h003, 20'h33333, 12'h001, 2'd2, 2'd1}, // R7 dir
    '{32'h0ABC_DEF0, 1'b1, 32'h0060_0000, 20'h00700, 12'h001, 20'h44444, 12'h003, 2'd2, 2'd2}, // R7 leaf
    '{32'h3333_3333, 1'b0, 32'h0070_0000, 20'h00800, 12'h003, 20'h55555, 12'h00B, 2'd0, 2'd2}, // R7 read ignores
    '{32'h5555_5555, 1'b1, 32'h0080_0000, 20'h00900, 12'h002, 20'h66666, 12'h001, 2'd1, 2'd1}, // R7 priority
    '{32'hFFFF_FFFF, 1'b0, 32'hFFFF_F000, 20'h0FFFF, 12'h001, 20'hFFFFF, 12'h001, 2'd0, 2'd2}, // R2 top index
    '{32'h0000_0000, 1'b1, 32'h0000_0000, 20'h00001, 12'h001, 20'h00002, 12'h00D, 2'd0, 2'd2}  // R3 zero
  };

  function automatic logic [31:0] dir_addr(input logic [31:0] b, input logic [31:0] va);
    return {b[31:12], va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] pte_addr(input logic [19:0] pb, input logic [31:0] va);
    return {pb, va[21:12], 2'b00};
  endfunction

  task automatic load_base(input logic [31:0] b);
    @(negedge clk);
    base_load = 1'b1; base_value = b;
    @(negedge clk);
    base_load = 1'b0;
  endtask

  // Issues one request and waits for its result; junk keeps req_valid high during the walk.
  task automatic walk(input logic [31:0] va, input logic wr, input bit junk,
                      output logic [1:0] code, output logic [31:0] pa, output logic cache);
    int t;
    n_reads = 0;
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    if (junk) begin
      req_vaddr = ~va; req_write = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    t = 0;
    while (!rsp_valid && t < 300) begin
      @(negedge clk);
      t++;
    end
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R11 response seen", {31'b0, rsp_valid}, 32'h1);
    code = rsp_code; pa = rsp_paddr; cache = rsp_cacheable;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 single pulse", {31'b0, rsp_valid}, 32'h0);
    chk(req_ready == 1'b1, "R9 ready again", {31'b0, req_ready}, 32'h1);
  endtask

  initial begin
    logic [1:0] code;
    logic [31:0] pa;
    logic cache;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
    chk(mem_req_valid == 1'b0, "R1 mem idle", {31'b0, mem_req_valid}, 32'h0);
    chk(rsp_valid == 1'b0, "R1 no result", {31'b0, rsp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] da, pta, exp_pa;
      logic exp_c;
      v = VECS[i];
      da  = dir_addr(v.base, v.va);
      pta = pte_addr(v.ptbase, v.va);
      mem.delete();
      mem[da]  = {v.ptbase, v.pde_ctl};
      mem[pta] = {v.ppn, v.pte_ctl};
      ready_gap = i % 3;
      rsp_gap   = (i * 2) % 5;
      load_base(v.base);
      walk(v.va, v.wr, 1'b0, code, pa, cache);
      exp_pa = (v.code == 2'd0) ? {v.ppn, v.va[11:0]} : 32'h0;
      exp_c  = (v.code == 2'd0) && v.pte_ctl[3];
      chk(seen[0] == da, "R2 directory address", seen[0], da);
      chk(n_reads == int'(v.nreads), "R5 R7 read count", n_reads, {30'b0, v.nreads});
      if (v.nreads == 2'd2)
        chk(seen[1] == pta, "R3 leaf address", seen[1], pta);
      chk(code == v.code, "R4 R5 R6 R7 code", {30'b0, code}, {30'b0, v.code});
      chk(pa == exp_pa, "R4 physical address", pa, exp_pa);
      chk(cache == exp_c, "R4 cacheable", {31'b0, cache}, {31'b0, exp_c});
    end

    // R10: load and accept in the same cycle
    mem.delete();
    mem[dir_addr(32'h0111_1000, 32'h0040_3123)] = {20'h00AAA, 12'h001};
    mem[dir_addr(32'h0222_2000, 32'h0040_3123)] = {20'h00BBB, 12'h001};
    mem[pte_addr(20'h00AAA, 32'h0040_3123)] = {20'h77777, 12'h001};
    mem[pte_addr(20'h00BBB, 32'h0040_3123)] = {20'h88888, 12'h001};
    ready_gap = 1; rsp_gap = 2;
    load_base(32'h0111_1000);
    @(negedge clk);
    base_load = 1'b1; base_value = 32'h0222_2000;
    walk(32'h0040_3123, 1'b0, 1'b0, code, pa, cache);
    base_load = 1'b0;
    chk(seen[0] == dir_addr(32'h0111_1000, 32'h0040_3123), "R10 old base used", seen[0],
        dir_addr(32'h0111_1000, 32'h0040_3123));
    chk(pa == 32'h7777_7123, "R10 old-base result", pa, 32'h7777_7123);
    walk(32'h0040_3123, 1'b0, 1'b0, code, pa, cache);
    chk(seen[0] == dir_addr(32'h0222_2000, 32'h0040_3123), "R10 new base used", seen[0],
        dir_addr(32'h0222_2000, 32'h0040_3123));
    chk(pa == 32'h8888_8123, "R10 new-base result", pa, 32'h8888_8123);

    // R9: request held high with other values during the walk is ignored
    ready_gap = 2; rsp_gap = 3;
    walk(32'h0040_3123, 1'b0, 1'b1, code, pa, cache);
    chk(n_reads == 2, "R9 no extra reads", n_reads, 32'd2);
    chk(seen[1] == pte_addr(20'h00BBB, 32'h0040_3123), "R9 leaf address kept", seen[1],
        pte_addr(20'h00BBB, 32'h0040_3123));
    chk(pa == 32'h8888_8123 && code == 2'd0, "R9 result unchanged", pa, 32'h8888_8123);
    repeat (4) @(negedge clk);
    chk(mem_req_valid == 1'b0 && req_ready == 1'b1, "R9 stays idle", {31'b0, mem_req_valid}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule